// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device side of a three-wire serial link to a small register file. A chip-enable line brackets each transfer. A serial clock times the bits. One bidirectional data line carries them, and it is split here into a data input, a data output and an output enable. The serial pins are brought into a faster system clock domain through two-flop synchronizers, and the block then detects their edges.

Each transfer opens with a command byte sent least significant bit first. The command names a register bank (clock/calendar or RAM) and a five-bit address, and it says whether the master reads or writes. It also carries an enable bit, and without that bit the transfer changes nothing. A write shifts in one data byte and issues a one-cycle write strobe on the register port. A read fetches one byte through the register port and drives it out, least significant bit first, on falling serial clock edges. After one data byte the block waits for chip-enable to drop. The system clock must be at least four times faster than the serial clock.

Top module: `tw_reg_slave`

## Requirements
- R1: When chip-enable goes low, any transfer in progress is abandoned at once. A data byte that is cut short produces no write strobe.
- R2: Whenever `ceIn` is low, `sdaOe` is 0.
- R3: The command byte is shifted in least significant bit first, one bit on each rising serial clock edge. Bit 0 is 0 for a write and 1 for a read. Bits 5..1 are the address, with bit 1 as the address LSB. Bit 6 is 0 for the clock/calendar bank and 1 for the RAM bank. Bit 7 is the enable.
- R4: If command bit 7 is 0, the transfer produces no write strobe and no read strobe, and `sdaOe` stays 0 until chip-enable falls.
- R5: For an enabled write command, the next eight rising edges shift in one data byte LSB first. Then `regWrEn` pulses high for exactly one system clock, with the command's bank, address and the byte on `regBank`, `regAddr` and `regWrData`.
- R6: For an enabled read command, `regRdEn` pulses for one cycle with the command's bank and address, and `regRdData` is captured. `sdaOe` stays 0 until the first falling edge after the eighth command bit. The captured byte then goes out LSB first, one bit per falling edge.
- R7: If the serial clock is high when chip-enable rises, the whole transfer is ignored until the next chip-enable rise.
- R8: Once one data byte has moved, further serial clock edges have no effect until chip-enable falls. There is no second strobe, and during a read the last bit and the driver both stay as they are.
- R9: After reset `sdaOe`, `regWrEn` and `regRdEn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceIn | input | 1 | Chip-enable from the master; high brackets a transfer |
| sclkIn | input | 1 | Serial clock from the master |
| sdaIn | input | 1 | Data line input |
| sdaOut | output | 1 | Data line output value |
| sdaOe | output | 1 | Data line output enable |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdEn | output | 1 | One-cycle register read strobe |
| regBank | output | 1 | Bank select from command (0 clock/calendar, 1 RAM) |
| regAddr | output | 5 | Register address from command |
| regWrData | output | 8 | Write data byte |
| regRdData | input | 8 | Read data, valid in the cycle of `regRdEn` |

## Verification
The bench sweeps every bank and address combination with both writes and reads. A design that mixed up bit order or field positions would write the wrong location or return a reversed byte. It aborts transfers partway through a data byte. A design that kept its shift state would then issue a stray write strobe or keep driving the line. It raises chip-enable while the serial clock is high, and sends commands with the enable bit clear. A careless design would act on either one. It also keeps clocking after the byte is done, which catches a design that wraps around into a second write or keeps shifting out read data.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DEC,
    ST_WDAT,
    ST_WSTB,
    ST_RDAT,
    ST_DONE
  } tw_state_e;

  typedef struct packed {
    logic cmdShift;
    logic wrShift;
    logic rdLoad;
    logic rdShift;
    logic oeClr;
  } tw_strobe_t;

endpackage

// File: rtl/tw_datapath.sv
module tw_datapath
  import tw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2,
  localparam int CMD_W = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceIn,
  input  logic              sclkIn,
  input  logic              sdaIn,
  input  tw_strobe_t        stb,
  output logic              ceSync,
  output logic              ceRise,
  output logic              sclkLvl,
  output logic              sclkRise,
  output logic              sclkFall,
  output logic              cmdEn,
  output logic              cmdRw,
  output logic              regBank,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              sdaOut,
  output logic              oeReg
);

  logic [SYNC_N-1:0] ceSh, sclkSh, sdaSh;
  logic cePrev, sclkPrev;
  logic sdaSync;
  logic [CMD_W-1:0]  cmdSr;
  logic [DATA_W-1:0] wrSr, outSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSh     <= '0;
      sclkSh   <= '0;
      sdaSh    <= '0;
      cePrev   <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      ceSh     <= {ceSh[SYNC_N-2:0], ceIn};
      sclkSh   <= {sclkSh[SYNC_N-2:0], sclkIn};
      sdaSh    <= {sdaSh[SYNC_N-2:0], sdaIn};
      cePrev   <= ceSh[SYNC_N-1];
      sclkPrev <= sclkSh[SYNC_N-1];
    end
  end

  assign ceSync   = ceSh[SYNC_N-1];
  assign sclkLvl  = sclkSh[SYNC_N-1];
  assign sdaSync  = sdaSh[SYNC_N-1];
  assign ceRise   = ceSync & ~cePrev;
  assign sclkRise = sclkLvl & ~sclkPrev;
  assign sclkFall = ~sclkLvl & sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSr  <= '0;
      wrSr   <= '0;
      outSr  <= '0;
      sdaOut <= 1'b0;
      oeReg  <= 1'b0;
    end else begin
      if (stb.cmdShift) cmdSr <= {sdaSync, cmdSr[CMD_W-1:1]};
      if (stb.wrShift)  wrSr  <= {sdaSync, wrSr[DATA_W-1:1]};
      if (stb.rdLoad) begin
        outSr <= regRdData;
      end else if (stb.rdShift) begin
        outSr  <= {1'b0, outSr[DATA_W-1:1]};
        sdaOut <= outSr[0];
      end
      if (stb.oeClr)        oeReg <= 1'b0;
      else if (stb.rdShift) oeReg <= 1'b1;
    end
  end

  assign cmdRw     = cmdSr[0];
  assign regAddr   = cmdSr[ADDR_W:1];
  assign regBank   = cmdSr[CMD_W-2];
  assign cmdEn     = cmdSr[CMD_W-1];
  assign regWrData = wrSr;

endmodule

// File: rtl/tw_control.sv
module tw_control
  import tw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int CMD_W = ADDR_W + 3,
  localparam int MAX_B = (CMD_W > DATA_W) ? CMD_W : DATA_W,
  localparam int CNT_W = $clog2(MAX_B)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceSync,
  input  logic       ceRise,
  input  logic       sclkLvl,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       cmdEn,
  input  logic       cmdRw,
  output tw_strobe_t stb,
  output logic       regWrEn,
  output logic       regRdEn
);

  tw_state_e state;
  logic [CNT_W-1:0] bitCnt;
  logic cmdLast, dataLast;

  assign cmdLast  = (bitCnt == CNT_W'(CMD_W - 1));
  assign dataLast = (bitCnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (!ceSync) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ceRise) begin
          state  <= sclkLvl ? ST_DONE : ST_CMD;
          bitCnt <= '0;
        end
        ST_CMD: if (sclkRise) begin
          if (cmdLast) begin
            state  <= ST_DEC;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_DEC: begin
          if (!cmdEn)     state <= ST_DONE;
          else if (cmdRw) state <= ST_RDAT;
          else            state <= ST_WDAT;
        end
        ST_WDAT: if (sclkRise) begin
          if (dataLast) begin
            state  <= ST_WSTB;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_WSTB: state <= ST_DONE;
        ST_RDAT: if (sclkFall) begin
          if (dataLast) begin
            state  <= ST_DONE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.cmdShift = ceSync && (state == ST_CMD) && sclkRise;
    stb.wrShift  = ceSync && (state == ST_WDAT) && sclkRise;
    stb.rdShift  = ceSync && (state == ST_RDAT) && sclkFall;
    stb.rdLoad   = regRdEn;
    stb.oeClr    = !ceSync;
  end

  assign regWrEn = (state == ST_WSTB);
  assign regRdEn = (state == ST_DEC) && cmdEn && cmdRw;

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceIn,
  input  logic              sclkIn,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              regBank,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData
);

  tw_strobe_t stb;
  logic ceSync, ceRise, sclkLvl, sclkRise, sclkFall, cmdEn, cmdRw, oeReg;

  tw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) dp_i (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .sclkIn(sclkIn), .sdaIn(sdaIn),
    .stb(stb), .ceSync(ceSync), .ceRise(ceRise), .sclkLvl(sclkLvl),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .cmdEn(cmdEn), .cmdRw(cmdRw),
    .regBank(regBank), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .sdaOut(sdaOut), .oeReg(oeReg)
  );

  tw_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctl_i (
    .clk(clk), .rstN(rstN), .ceSync(ceSync), .ceRise(ceRise),
    .sclkLvl(sclkLvl), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .cmdEn(cmdEn), .cmdRw(cmdRw), .stb(stb),
    .regWrEn(regWrEn), .regRdEn(regRdEn)
  );

  // Raw pin gating releases the line without waiting for the synchronizer.
  assign sdaOe = oeReg & ceIn;

endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk (
  input logic clk,
  input logic rstN,
  input logic ceIn,
  input logic regWrEn,
  input logic regRdEn
);

  a_r5_wr_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  a_r6_rd_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  a_r3_wr_rd_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  a_r1_quiet_ce_low: assert property (@(posedge clk) disable iff (!rstN)
    (!ceIn && $past(!ceIn) && $past(!ceIn, 2) && $past(!ceIn, 3))
      |-> (!regWrEn && !regRdEn));

endmodule

bind tw_reg_slave tw_reg_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .ceIn(ceIn), .regWrEn(regWrEn), .regRdEn(regRdEn)
);

// File: tb/tw_reg_slave_tb.sv
module tw_reg_slave_tb_top;

  localparam int H = 5;  // serial half period in system clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceIn = 1'b0, sclkIn = 1'b0, sdaIn = 1'b0;
  logic sdaOut, sdaOe, regWrEn, regRdEn, regBank;
  logic [4:0] regAddr;
  logic [7:0] regWrData, regRdData;

  int total = 0, bad = 0;
  int wrCount = 0, rdCount = 0, oeSeen = 0;
  logic [7:0] lastWrData;
  logic [4:0] lastWrAddr, lastRdAddr;
  logic lastWrBank, lastRdBank;

  always #10 clk = ~clk;  // 50 MHz

  tw_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .sclkIn(sclkIn), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regBank(regBank), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  function automatic logic [7:0] rdVal(input logic b, input logic [4:0] a);
    return {a, b, 2'b01} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] wrVal(input logic b, input logic [4:0] a);
    return 8'((int'(a) * 7 + int'(b) * 91 + 13) & 255);
  endfunction

  assign regRdData = rdVal(regBank, regAddr);

  always @(posedge clk) begin
    if (regWrEn) begin
      wrCount++;
      lastWrData = regWrData; lastWrAddr = regAddr; lastWrBank = regBank;
    end
    if (regRdEn) begin
      rdCount++;
      lastRdAddr = regAddr; lastRdBank = regBank;
    end
    if (sdaOe) oeSeen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startXfer();
    sclkIn = 1'b0; waitN(2); ceIn = 1'b1; waitN(H);
  endtask

  task automatic endXfer();
    sclkIn = 1'b0; waitN(H); ceIn = 1'b0; waitN(H + 2);
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sclkIn = 1'b0; sdaIn = v[i]; waitN(H);
      sclkIn = 1'b1; waitN(H);
    end
  endtask

  function automatic logic [7:0] mkCmd(input logic en, input logic b,
                                       input logic [4:0] a, input logic rd);
    return {en, b, a, rd};
  endfunction

  task automatic readByte(output logic [7:0] v, output int oeOk);
    oeOk = 1;
    for (int i = 0; i < 8; i++) begin
      sclkIn = 1'b0; waitN(H);
      v[i] = sdaOut;
      if (!sdaOe) oeOk = 0;
      sclkIn = 1'b1; waitN(H);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int oeOk, w0, r0;
    waitN(5);
    // R9 reset state
    chk(!sdaOe && !regWrEn && !regRdEn, "R9 reset outputs", {sdaOe, regWrEn, regRdEn}, 0);
    rstN = 1'b1; waitN(3);

    // R3 R5 write sweep over every bank/address
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 32; a++) begin
        w0 = wrCount;
        startXfer();
        sendBits(mkCmd(1'b1, 1'(b), 5'(a), 1'b0), 8);
        sendBits(wrVal(1'(b), 5'(a)), 8);
        endXfer();
        chk(wrCount == w0 + 1, "R5 one strobe", wrCount - w0, 1);
        chk(lastWrData == wrVal(1'(b), 5'(a)), "R5 data", lastWrData, wrVal(1'(b), 5'(a)));
        chk(lastWrAddr == 5'(a) && lastWrBank == 1'(b), "R3 write address/bank",
            {lastWrBank, lastWrAddr}, {b[0], 5'(a)});
      end
    end

    // R6 read sweep
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 32; a++) begin
        r0 = rdCount;
        startXfer();
        sendBits(mkCmd(1'b1, 1'(b), 5'(a), 1'b1), 8);
        chk(!sdaOe, "R6 no drive before first falling edge", sdaOe, 0);
        readByte(got, oeOk);
        chk(got == rdVal(1'(b), 5'(a)), "R6 read byte LSB first", got, rdVal(1'(b), 5'(a)));
        chk(oeOk == 1, "R6 driver on during byte", oeOk, 1);
        chk(rdCount == r0 + 1 && lastRdAddr == 5'(a) && lastRdBank == 1'(b),
            "R6 read strobe", {lastRdBank, lastRdAddr}, {b[0], 5'(a)});
        endXfer();
        chk(!sdaOe, "R2 released after ce low", sdaOe, 0);
      end
    end

    // R8 extra edges after write byte
    w0 = wrCount;
    startXfer();
    sendBits(mkCmd(1'b1, 1'b1, 5'd9, 1'b0), 8);
    sendBits(8'hC3, 8);
    sendBits(8'h5A, 8);
    endXfer();
    chk(wrCount == w0 + 1 && lastWrData == 8'hC3, "R8 no second write", wrCount - w0, 1);

    // R8 extra edges after read byte: last bit and driver hold
    startXfer();
    sendBits(mkCmd(1'b1, 1'b0, 5'd22, 1'b1), 8);
    readByte(got, oeOk);
    sendBits(8'h00, 4);
    sclkIn = 1'b0; waitN(H);
    chk(sdaOe && sdaOut == rdVal(1'b0, 5'd22)[7], "R8 read holds last bit",
        {sdaOe, sdaOut}, {1'b1, rdVal(1'b0, 5'd22)[7]});
    endXfer();

    // R4 enable bit clear: write and read ignored
    w0 = wrCount; r0 = rdCount; oeSeen = 0;
    startXfer();
    sendBits(mkCmd(1'b0, 1'b0, 5'd3, 1'b0), 8);
    sendBits(8'hFF, 8);
    endXfer();
    startXfer();
    sendBits(mkCmd(1'b0, 1'b1, 5'd3, 1'b1), 8);
    readByte(got, oeOk);
    endXfer();
    chk(wrCount == w0, "R4 no write when disabled", wrCount - w0, 0);
    chk(rdCount == r0, "R4 no read when disabled", rdCount - r0, 0);
    chk(oeSeen == 0, "R4 line never driven", oeSeen, 0);

    // R1 abort partway through data byte
    w0 = wrCount;
    startXfer();
    sendBits(mkCmd(1'b1, 1'b0, 5'd17, 1'b0), 8);
    sendBits(8'hAA, 4);
    ceIn = 1'b0; waitN(H + 2); sclkIn = 1'b0; waitN(H);
    chk(wrCount == w0, "R1 aborted write no strobe", wrCount - w0, 0);

    // R1 R2 abort during read: driver released at once
    startXfer();
    sendBits(mkCmd(1'b1, 1'b1, 5'd5, 1'b1), 8);
    sclkIn = 1'b0; waitN(H);
    chk(sdaOe, "R6 driving after first fall", sdaOe, 1);
    ceIn = 1'b0; waitN(1);
    chk(!sdaOe, "R2 driver off with ce low", sdaOe, 0);
    waitN(H + 2);
    // R1 next transfer starts clean
    w0 = wrCount;
    startXfer();
    sendBits(mkCmd(1'b1, 1'b1, 5'd30, 1'b0), 8);
    sendBits(8'h81, 8);
    endXfer();
    chk(wrCount == w0 + 1 && lastWrData == 8'h81 && lastWrAddr == 5'd30,
        "R1 clean restart", lastWrData, 8'h81);

    // R7 sclk high at ce rise
    w0 = wrCount; r0 = rdCount;
    sclkIn = 1'b1; waitN(3); ceIn = 1'b1; waitN(H);
    sendBits(mkCmd(1'b1, 1'b0, 5'd11, 1'b0), 8);
    sendBits(8'h77, 8);
    endXfer();
    chk(wrCount == w0 && rdCount == r0, "R7 transfer ignored", wrCount - w0, 0);
    startXfer();
    sendBits(mkCmd(1'b1, 1'b0, 5'd11, 1'b0), 8);
    sendBits(8'h77, 8);
    endXfer();
    chk(wrCount == w0 + 1 && lastWrData == 8'h77, "R7 next transfer works", wrCount - w0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule